// File: doc/BRIEF.md
# In-Frame Response Transmit Sequencer

This block drives the transmit side of an in-frame response on a J1850-style serial bus. A host arms a response while another node's frame is still arriving. It chooses one of two variants: the response bytes followed by a CRC byte, or the response bytes alone. The armed response waits until the bus reports the end-of-data that closes the frame's main part, and only then starts. If another node answers first or the frame is received in error, the arming is dropped. If neither happens and no end-of-data arrives, the arming carries over to the next received frame.

Once started, the block sends the byte held in its data register, marked as needing a normalization bit ahead of it. It then asks the host for each further byte through a transmit-empty status code. When the host marks end of data, the block closes the response with the CRC byte if that variant was armed, and then an EOD request. It waits for end of frame and signals completion. Arbitration loss, a bus symbol error or a late refill from the host aborts the response, clears the control bits and leaves an exception code in the status vector.

The bus side is a byte-level symbol engine. The block issues one request at a time and advances when the engine reports that the request has been sent.

Top module: `ifr_tx_seq`

## Requirements
- R1: `ctl_bits` shows bit 0 = CRC variant armed, bit 1 = no-CRC variant armed, bit 2 = end-of-data marked. While idle, a pulse on `arm_crc_set` or `arm_nocrc_set` arms that variant and disarms the other. If both pulse together, the CRC variant is armed. At most one variant is ever armed.
- R2: A response starts only on the clock edge that samples `bus_eod_rx` while a variant is armed. An end-of-data with nothing armed produces no request. An arming that sees no end-of-data stays in place for a later frame.
- R3: While idle and armed, `bus_other_ifr` or `bus_rx_err` clears all three control bits, and a later end-of-data produces no request.
- R4: The first request has `tx_kind` 0 (normalization bit, then byte). It appears on the edge that samples `bus_eod_rx`, and `tx_data` equals the most recent host write.
- R5: After a byte is taken while end of data is not marked and no new write arrives, `status` reads 1 (transmit register empty). A host write returns it to 0.
- R6: On the edge that samples `bus_done` for a data byte with the register refilled, a request with `tx_kind` 1 carries the refilled byte.
- R7: On `bus_done` for a data byte with the register empty and end of data marked, the CRC variant issues `tx_kind` 2. Its `tx_data` is the J1850 CRC-8 (polynomial 0x1D, preset 0xFF, result inverted, MSB first) over the response bytes only, and 0x4B for the ASCII bytes "123456789". The next `bus_done` issues `tx_kind` 3 (EOD). The no-CRC variant issues `tx_kind` 3 directly.
- R8: Arming together with marking end of data gives a one-byte response, with no transmit-empty indication.
- R9: `bus_arb_lost` during a response clears the control bits and pulses `tx_abort`. It sets `status` to 3 and returns to idle, and any held byte is discarded.
- R10: `bus_sym_err` during a response does the same with `status` 4. When both arrive together, the error code wins.
- R11: An underrun sets `status` to 2 and clears the control bits. An underrun is either `bus_done` for a data byte with the register empty and end of data not marked, or a start with the register empty.
- R12: After the EOD request completes, no further request is issued. On `bus_eof`, `rsp_done` pulses for exactly one cycle and the control bits clear.
- R13: An exception code (2, 3 or 4) stays on `status` until the host next arms a variant, which returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Data register write strobe |
| host_wdata | input | BYTE_W | Data register write value |
| arm_crc_set | input | 1 | Arm response with CRC |
| arm_nocrc_set | input | 1 | Arm response without CRC |
| eod_set | input | 1 | Mark end of response data |
| status | output | 3 | 0 none, 1 transmit empty, 2 underrun, 3 arbitration lost, 4 bus error |
| ctl_bits | output | 3 | {end-of-data, no-CRC armed, CRC armed} |
| bus_eod_rx | input | 1 | End of data of an incoming frame seen |
| bus_other_ifr | input | 1 | Another node is responding to the frame |
| bus_rx_err | input | 1 | Receive error on the frame |
| bus_arb_lost | input | 1 | Arbitration lost on current transmission |
| bus_sym_err | input | 1 | Invalid or out-of-range symbol detected |
| bus_done | input | 1 | Symbol engine finished the current request |
| bus_eof | input | 1 | End of frame detected |
| tx_req | output | 1 | One-cycle request to the symbol engine |
| tx_kind | output | 2 | 0 normalization bit then byte, 1 byte, 2 CRC, 3 EOD |
| tx_data | output | BYTE_W | Byte for the request |
| tx_abort | output | 1 | One-cycle pulse discarding the request in flight |
| rsp_done | output | 1 | One-cycle response-complete pulse |

## Verification
The bench uses the default parameters: an 8-bit byte, polynomial 0x1D and preset 0xFF. These settings make the published check value 0x4B of the J1850 CRC-8 a direct anchor for the CRC byte, alongside a bench-side model of the same CRC. Random responses of one to six bytes, with both variants and random spacing between engine completions, reach the refill path, the transmit-empty handshake and the one-byte path. Directed runs cover the three exception sources, their priority and the disarming events.

// File: rtl/ifr_pkg.sv
package ifr_pkg;
  localparam int STAT_W = 3;
  localparam int KIND_W = 2;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_CRC, S_EOD, S_EOF} seq_state_t;
  typedef enum logic [KIND_W-1:0] {K_FIRST = 2'd0, K_DATA = 2'd1, K_CRC = 2'd2, K_EOD = 2'd3} req_kind_t;
  typedef enum logic [STAT_W-1:0] {
    ST_NONE = 3'd0, ST_EMPTY = 3'd1, ST_UNDER = 3'd2, ST_ARB = 3'd3, ST_ERR = 3'd4
  } stat_code_t;
endpackage

// File: rtl/ifr_crc_acc.sv
module ifr_crc_acc #(
  parameter int W = 8,
  parameter logic [W-1:0] POLY = 'h1D,
  parameter logic [W-1:0] INIT = 'hFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         step,
  input  logic [W-1:0] din,
  output logic [W-1:0] crc_q
);
  function automatic logic [W-1:0] fold(input logic [W-1:0] c, input logic [W-1:0] d);
    logic [W-1:0] r;
    logic fb;
    r = c;
    for (int b = W - 1; b >= 0; b--) begin
      fb = r[W-1] ^ d[b];
      r  = {r[W-2:0], 1'b0};
      if (fb) r = r ^ POLY;
    end
    return r;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)        crc_q <= INIT;
    else if (start) crc_q <= fold(INIT, din);
    else if (step)  crc_q <= fold(crc_q, din);
  end
endmodule

// File: rtl/ifr_stat_enc.sv
module ifr_stat_enc
  import ifr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              err_f,
  input  logic              arb_f,
  input  logic              und_f,
  input  logic              empty_f,
  output logic [STAT_W-1:0] code
);
  stat_code_t c;
  always_comb begin
    if (err_f)        c = ST_ERR;
    else if (arb_f)   c = ST_ARB;
    else if (und_f)   c = ST_UNDER;
    else if (empty_f) c = ST_EMPTY;
    else              c = ST_NONE;
  end
  assign code = c;

  // R10
  exc_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({err_f, arb_f, und_f}))
    else $error("exception flags not one-hot");
endmodule

// File: rtl/ifr_tx_seq.sv
module ifr_tx_seq
  import ifr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [BYTE_W-1:0] CRC_POLY = 'h1D,
  parameter logic [BYTE_W-1:0] CRC_INIT = 'hFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_wr,
  input  logic [BYTE_W-1:0] host_wdata,
  input  logic              arm_crc_set,
  input  logic              arm_nocrc_set,
  input  logic              eod_set,
  output logic [STAT_W-1:0] status,
  output logic [2:0]        ctl_bits,
  input  logic              bus_eod_rx,
  input  logic              bus_other_ifr,
  input  logic              bus_rx_err,
  input  logic              bus_arb_lost,
  input  logic              bus_sym_err,
  input  logic              bus_done,
  input  logic              bus_eof,
  output logic              tx_req,
  output logic [KIND_W-1:0] tx_kind,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_abort,
  output logic              rsp_done
);
  seq_state_t        state;
  logic [BYTE_W-1:0] dreg, crc_q;
  logic dfull, arm_crc, arm_nocrc, eod_f, empty_f, err_f, arb_f, und_f;
  logic armed, active, abort, disarm, fire, take_first, take_next;

  assign armed      = arm_crc | arm_nocrc;
  assign active     = (state == S_DATA) || (state == S_CRC) || (state == S_EOD);
  assign abort      = active && (bus_arb_lost || bus_sym_err);
  assign disarm     = (state == S_IDLE) && armed && (bus_other_ifr || bus_rx_err);
  assign fire       = (state == S_IDLE) && armed && !disarm && bus_eod_rx;
  assign take_first = fire && dfull;
  assign take_next  = (state == S_DATA) && bus_done && dfull && !abort;
  assign ctl_bits   = {eod_f, arm_nocrc, arm_crc};

  ifr_crc_acc #(.W(BYTE_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc (
    .clk(clk), .rst(rst), .start(take_first), .step(take_next), .din(dreg), .crc_q(crc_q)
  );

  ifr_stat_enc i_stat (
    .clk(clk), .rst(rst), .err_f(err_f), .arb_f(arb_f), .und_f(und_f),
    .empty_f(empty_f), .code(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; dreg <= '0; dfull <= 1'b0;
      arm_crc <= 1'b0; arm_nocrc <= 1'b0; eod_f <= 1'b0;
      empty_f <= 1'b0; err_f <= 1'b0; arb_f <= 1'b0; und_f <= 1'b0;
      tx_req <= 1'b0; tx_kind <= K_FIRST; tx_data <= '0;
      tx_abort <= 1'b0; rsp_done <= 1'b0;
    end else begin
      tx_req   <= 1'b0;
      tx_abort <= 1'b0;
      rsp_done <= 1'b0;
      if (host_wr) begin
        dreg <= host_wdata; dfull <= 1'b1; empty_f <= 1'b0;
      end
      case (state)
        S_IDLE: begin
          if (disarm) begin
            arm_crc <= 1'b0; arm_nocrc <= 1'b0; eod_f <= 1'b0;
          end else if (arm_crc_set || arm_nocrc_set) begin
            arm_crc <= arm_crc_set; arm_nocrc <= !arm_crc_set; eod_f <= eod_set;
            err_f <= 1'b0; arb_f <= 1'b0; und_f <= 1'b0;
          end else if (eod_set && armed) begin
            eod_f <= 1'b1;
          end
          if (fire) begin
            if (dfull) begin
              tx_req <= 1'b1; tx_kind <= K_FIRST; tx_data <= dreg;
              dfull <= host_wr; empty_f <= !host_wr && !eod_f;
              state <= S_DATA;
            end else begin
              und_f <= 1'b1; err_f <= 1'b0; arb_f <= 1'b0;
              arm_crc <= 1'b0; arm_nocrc <= 1'b0; eod_f <= 1'b0;
            end
          end
        end
        S_DATA: begin
          if (eod_set) begin
            eod_f <= 1'b1; empty_f <= 1'b0;
          end
          if (bus_done) begin
            if (dfull) begin
              tx_req <= 1'b1; tx_kind <= K_DATA; tx_data <= dreg;
              dfull <= host_wr; empty_f <= !host_wr && !eod_f && !eod_set;
            end else if (eod_f) begin
              tx_req <= 1'b1;
              if (arm_crc) begin
                tx_kind <= K_CRC; tx_data <= ~crc_q; state <= S_CRC;
              end else begin
                tx_kind <= K_EOD; tx_data <= '0; state <= S_EOD;
              end
            end else begin
              und_f <= 1'b1; err_f <= 1'b0; arb_f <= 1'b0; tx_abort <= 1'b1;
              arm_crc <= 1'b0; arm_nocrc <= 1'b0; eod_f <= 1'b0; empty_f <= 1'b0;
              state <= S_IDLE;
            end
          end
        end
        S_CRC: if (bus_done) begin
          tx_req <= 1'b1; tx_kind <= K_EOD; tx_data <= '0; state <= S_EOD;
        end
        S_EOD: if (bus_done) state <= S_EOF;
        S_EOF: if (bus_eof) begin
          rsp_done <= 1'b1; empty_f <= 1'b0;
          arm_crc <= 1'b0; arm_nocrc <= 1'b0; eod_f <= 1'b0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (abort) begin
        arm_crc <= 1'b0; arm_nocrc <= 1'b0; eod_f <= 1'b0;
        empty_f <= 1'b0; dfull <= 1'b0; tx_req <= 1'b0; tx_abort <= 1'b1;
        err_f <= bus_sym_err; arb_f <= !bus_sym_err; und_f <= 1'b0;
        state <= S_IDLE;
      end
    end
  end

  // R1
  arm_excl_chk: assert property (@(posedge clk) disable iff (rst) !(arm_crc && arm_nocrc))
    else $error("both variants armed");
  // R2
  start_on_eod_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_kind == K_FIRST) |-> $past(bus_eod_rx))
    else $error("response started without end-of-data");
  // R7
  crc_variant_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_kind == K_CRC) |-> arm_crc)
    else $error("CRC sent for no-CRC variant");
  // R9
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (ctl_bits == 3'b000 && !tx_req && tx_abort))
    else $error("abort left control bits or request");
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done)
    else $error("completion pulse longer than a cycle");
endmodule

// File: tb/test_ifr_tx_seq.sv
module test_ifr_tx_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_wr = 0, arm_crc_set = 0, arm_nocrc_set = 0, eod_set = 0;
  logic [7:0] host_wdata = '0;
  logic bus_eod_rx = 0, bus_other_ifr = 0, bus_rx_err = 0, bus_arb_lost = 0;
  logic bus_sym_err = 0, bus_done = 0, bus_eof = 0;
  logic [2:0] status, ctl_bits;
  logic tx_req, tx_abort, rsp_done;
  logic [1:0] tx_kind;
  logic [7:0] tx_data;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] buf_q [16];
  logic [7:0] last_crc;

  always #2.5 clk = ~clk;

  ifr_tx_seq i_ifr_tx_seq (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_wdata(host_wdata),
    .arm_crc_set(arm_crc_set), .arm_nocrc_set(arm_nocrc_set), .eod_set(eod_set),
    .status(status), .ctl_bits(ctl_bits), .bus_eod_rx(bus_eod_rx),
    .bus_other_ifr(bus_other_ifr), .bus_rx_err(bus_rx_err), .bus_arb_lost(bus_arb_lost),
    .bus_sym_err(bus_sym_err), .bus_done(bus_done), .bus_eof(bus_eof),
    .tx_req(tx_req), .tx_kind(tx_kind), .tx_data(tx_data),
    .tx_abort(tx_abort), .rsp_done(rsp_done)
  );

  function automatic logic [7:0] crc_fold(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      logic fb = r[7] ^ d[b];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h1D;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    host_wdata = d; host_wr = 1; @(negedge clk); host_wr = 0;
  endtask

  task automatic arm(input bit c, input bit nc, input bit e);
    arm_crc_set = c; arm_nocrc_set = nc; eod_set = e;
    @(negedge clk);
    arm_crc_set = 0; arm_nocrc_set = 0; eod_set = 0;
  endtask

  // 0 eod_rx, 1 other, 2 rx_err, 3 arb, 4 sym, 5 done, 6 eof, 7 eod_set, 8 arb+sym
  task automatic pulse(input int w);
    case (w)
      0: bus_eod_rx = 1;
      1: bus_other_ifr = 1;
      2: bus_rx_err = 1;
      3: bus_arb_lost = 1;
      4: bus_sym_err = 1;
      5: bus_done = 1;
      6: bus_eof = 1;
      7: eod_set = 1;
      default: begin bus_arb_lost = 1; bus_sym_err = 1; end
    endcase
    @(negedge clk);
    bus_eod_rx = 0; bus_other_ifr = 0; bus_rx_err = 0; bus_arb_lost = 0;
    bus_sym_err = 0; bus_done = 0; bus_eof = 0; eod_set = 0;
  endtask

  task automatic run_rsp(input int n, input bit wc, input int gap);
    logic [7:0] c = 8'hFF;
    wr(buf_q[0]);
    arm(wc, !wc, n == 1);
    chk(ctl_bits == {n == 1, !wc, wc}, "R1", ctl_bits, {n == 1, !wc, wc});
    idle(gap);
    pulse(0);
    chk(tx_req && tx_kind == 0 && tx_data == buf_q[0], "R4", tx_data, buf_q[0]);
    c = crc_fold(c, buf_q[0]);
    for (int i = 1; i < n; i++) begin
      chk(status == 1, "R5", status, 1);
      wr(buf_q[i]);
      chk(status == 0, "R5", status, 0);
      idle(gap);
      pulse(5);
      chk(tx_req && tx_kind == 1 && tx_data == buf_q[i], "R6", tx_data, buf_q[i]);
      c = crc_fold(c, buf_q[i]);
    end
    if (n > 1) begin
      pulse(7);
      chk(status == 0 && ctl_bits[2], "R7", status, 0);
    end else begin
      chk(status == 0, "R8", status, 0);
    end
    idle(gap);
    pulse(5);
    if (wc) begin
      chk(tx_req && tx_kind == 2 && tx_data == ~c, "R7", tx_data, ~c);
      last_crc = tx_data;
      idle(gap);
      pulse(5);
    end
    chk(tx_req && tx_kind == 3, "R7", tx_kind, 3);
    idle(gap);
    pulse(5);
    chk(!tx_req, "R12", tx_req, 0);
    idle(gap);
    pulse(6);
    chk(rsp_done && ctl_bits == 0, "R12", rsp_done, 1);
    @(negedge clk);
    chk(!rsp_done, "R12", rsp_done, 0);
  endtask

  task automatic start_rsp(input logic [7:0] d);
    wr(d); arm(1, 0, 0); pulse(0);
  endtask

  initial begin
    int r;
    r = $urandom(32'd2024);
    idle(3);
    rst = 0;
    @(negedge clk);
    chk(status == 0 && ctl_bits == 0 && !tx_req && !rsp_done, "reset", status, 0);

    // R1 both arm bits together, then the other one alone
    arm(1, 1, 0);
    chk(ctl_bits == 3'b001, "R1", ctl_bits, 3'b001);
    arm(0, 1, 0);
    chk(ctl_bits == 3'b010, "R1", ctl_bits, 3'b010);
    pulse(1);
    chk(ctl_bits == 3'b000, "R3", ctl_bits, 0);

    // R2 unarmed end-of-data, then arming held across a frame
    wr(8'h5A);
    pulse(0);
    chk(!tx_req, "R2", tx_req, 0);
    arm(0, 1, 0);
    pulse(6);
    idle(2);
    pulse(0);
    chk(tx_req && tx_kind == 0 && tx_data == 8'h5A, "R2", tx_data, 8'h5A);
    pulse(3);
    chk(status == 3 && ctl_bits == 0 && tx_abort, "R9", status, 3);
    pulse(0);
    chk(!tx_req, "R9", tx_req, 0);

    // R3 disarm by another responder and by receive error
    wr(8'h11); arm(1, 0, 0); pulse(1);
    chk(ctl_bits == 0, "R3", ctl_bits, 0);
    pulse(0);
    chk(!tx_req, "R3", tx_req, 0);
    arm(0, 1, 0); pulse(2);
    chk(ctl_bits == 0, "R3", ctl_bits, 0);

    // R4 overwritten first byte
    wr(8'hA1); wr(8'hB2); arm(1, 0, 0); pulse(0);
    chk(tx_req && tx_data == 8'hB2, "R4", tx_data, 8'hB2);
    pulse(4);
    chk(status == 4 && ctl_bits == 0, "R10", status, 4);

    // R10 error beats arbitration loss
    start_rsp(8'h33);
    pulse(8);
    chk(status == 4 && tx_abort, "R10", status, 4);

    // R11 underrun after first byte, R13 hold and release
    start_rsp(8'h44);
    pulse(5);
    chk(status == 2 && ctl_bits == 0 && tx_abort && !tx_req, "R11", status, 2);
    idle(4);
    chk(status == 2, "R13", status, 2);
    arm(0, 1, 0);
    chk(status == 0, "R13", status, 0);
    pulse(0);
    chk(status == 2 && !tx_req && ctl_bits == 0, "R11", status, 2);

    // R7 check value over "123456789"
    for (int i = 0; i < 9; i++) buf_q[i] = 8'h31 + 8'(i);
    run_rsp(9, 1, 1);
    chk(last_crc == 8'h4B, "R7", last_crc, 8'h4B);

    // R8 single byte without CRC
    buf_q[0] = 8'hC3;
    run_rsp(1, 0, 0);

    // random responses
    for (int t = 0; t < 16; t++) begin
      int n = 1 + int'($urandom % 6);
      for (int i = 0; i < n; i++) buf_q[i] = 8'($urandom);
      run_rsp(n, 1'($urandom), int'($urandom % 3));
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule